// File: doc/BRIEF.md
# Video Scan-Out Bus Arbiter

This block lets one system RAM serve both a CPU and a scan-out video engine. Two blanking flags come from the display timing counters. From them the block works out when the picture is being drawn. During that window it takes the bus away from the CPU. It drives an active-low DMA line that pauses the processor and releases its address and data drivers. The video scan address, with a fixed upper field, then goes onto the bus. The block also produces the RAM strobes for a read-only access.

While the display is blanked, the CPU gets the bus back. CPU accesses to RAM are gated by the CPU clock phase, so a chip select can never open during the first half of a CPU cycle. A mode input shrinks the CPU's share to the vertical blanking interval alone. In that mode the CPU stays stalled across horizontal blanking and cannot disturb the picture.

The video request comes from the pixel-clock domain. It passes through a synchronizer, and ownership is then registered on the CPU clock edge. A change of owner therefore lands only on a CPU cycle boundary.

Top module: `vdma_bus_arbiter`

## Requirements
- R1: With `vblank_only` low, video ownership is requested only while both `hblank` and `vblank` are low.
- R2: With `vblank_only` high, video ownership is requested whenever `vblank` is low, whatever the value of `hblank`.
- R3: The request passes through SYNC_STAGES flops clocked by `clk`. The owner register loads the synchronized request only in a cycle where `cpu_tick` is high, so `dma_n` changes only in the cycle after a tick.
- R4: While `dma_n` is low, `cpu_rdy`, `cpu_be` and `cpu_buf_oe` are low and `vid_buf_oe` is high. While `dma_n` is high, all four take the opposite values.
- R5: While `dma_n` is low, `bus_addr` is {VID_TOP, scan_addr}, with VID_TOP defaulting to 3'b001 (bits 15 and 14 low, bit 13 high). While `dma_n` is high, `bus_addr` equals `cpu_addr`.
- R6: `bus_rw` (1 = read) is 1 while `dma_n` is low and equals `cpu_rw` otherwise.
- R7: `ram_oe_n` equals `bus_addr[14]`.
- R8: While `dma_n` is low, `ram_cs_n` equals `bus_addr[15]` whatever the value of `cpu_phase`.
- R9: While `dma_n` is high, `ram_cs_n` is low only when `bus_addr[15]` is low and `cpu_phase` is high (the second half of the CPU cycle).
- R10: After reset the CPU owns the bus: `dma_n` is high and remains high until a registered request arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank | input | 1 | Horizontal blanking flag from the timing counters |
| vblank | input | 1 | Vertical blanking flag from the timing counters |
| vblank_only | input | 1 | 1 = CPU may own the bus only during vertical blanking |
| cpu_tick | input | 1 | One-cycle strobe marking the CPU clock edge |
| cpu_phase | input | 1 | CPU clock level; 1 = second half of the CPU cycle |
| scan_addr | input | 13 | Video scan address, low bits |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| dma_n | output | 1 | Active-low video ownership and CPU stall |
| cpu_rdy | output | 1 | CPU ready input, low = pause |
| cpu_be | output | 1 | CPU bus enable, low = CPU drivers released |
| cpu_buf_oe | output | 1 | Enable for the CPU-side tri-state drivers |
| vid_buf_oe | output | 1 | Enable for the video-side bus buffers |
| bus_addr | output | 16 | Address driven to RAM |
| bus_rw | output | 1 | Read/write to RAM, 1 = read |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |

## Verification
The hardest case to reach is a change in the blanking request that lasts a few cycles and falls between two CPU edges. Only such a change shows whether ownership really waits for `cpu_tick` and whether the synchronizer delay is right. The bench produces it in two ways: it feeds short random blanking glitches against a CPU clock of varying phase, and it sweeps small display rasters in both modes. A behavioural queue model predicts the owner on every cycle, so the bench also catches a pulse that is missed or taken one edge too early.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  localparam int ADDR_W = 16;
  localparam int TOP_W  = 3;
  localparam int SCAN_W = ADDR_W - TOP_W;

  // Video owns the bus inside the drawing window; in vblank_only mode
  // the horizontal blanking gaps also belong to video.
  function automatic logic want_video(input logic hb, input logic vb,
                                      input logic vb_only);
    return vb_only ? !vb : (!hb && !vb);
  endfunction

  function automatic logic [ADDR_W-1:0] scan_bus_addr(
      input logic [TOP_W-1:0] top, input logic [SCAN_W-1:0] low);
    return {top, low};
  endfunction

  // RAM selected when bit 15 decodes low and either video owns the bus
  // or the CPU is in the second half of its cycle.
  function automatic logic cs_active(input logic a15, input logic vid_own,
                                     input logic phase);
    return !a15 && (vid_own || phase);
  endfunction

endpackage

// File: rtl/vdma_window.sv
module vdma_window (
  input  logic hblank,
  input  logic vblank,
  input  logic vblank_only,
  output logic want
);
  import vdma_pkg::*;
  always_comb want = want_video(hblank, vblank, vblank_only);
endmodule

// File: rtl/vdma_sync.sv
module vdma_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vdma_owner.sv
module vdma_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_tick,
  input  logic req_sync,
  output logic vid_own
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        vid_own <= 1'b0;
    else if (cpu_tick) vid_own <= req_sync;
endmodule

// File: rtl/vdma_ramctl.sv
module vdma_ramctl #(
  parameter logic [vdma_pkg::TOP_W-1:0] VID_TOP = 3'b001
) (
  input  logic                         vid_own,
  input  logic                         cpu_phase,
  input  logic [vdma_pkg::SCAN_W-1:0]  scan_addr,
  input  logic [vdma_pkg::ADDR_W-1:0]  cpu_addr,
  input  logic                         cpu_rw,
  output logic [vdma_pkg::ADDR_W-1:0]  bus_addr,
  output logic                         bus_rw,
  output logic                         ram_cs_n,
  output logic                         ram_oe_n
);
  import vdma_pkg::*;
  always_comb begin
    bus_addr = vid_own ? scan_bus_addr(VID_TOP, scan_addr) : cpu_addr;
    bus_rw   = vid_own ? 1'b1 : cpu_rw;
    ram_cs_n = !cs_active(bus_addr[ADDR_W-1], vid_own, cpu_phase);
    ram_oe_n = bus_addr[ADDR_W-2];
  end
endmodule

// File: rtl/vdma_bus_arbiter.sv
module vdma_bus_arbiter #(
  parameter int   SYNC_STAGES = 2,
  parameter logic [2:0] VID_TOP = 3'b001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hblank,
  input  logic        vblank,
  input  logic        vblank_only,
  input  logic        cpu_tick,
  input  logic        cpu_phase,
  input  logic [12:0] scan_addr,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_rw,
  output logic        dma_n,
  output logic        cpu_rdy,
  output logic        cpu_be,
  output logic        cpu_buf_oe,
  output logic        vid_buf_oe,
  output logic [15:0] bus_addr,
  output logic        bus_rw,
  output logic        ram_cs_n,
  output logic        ram_oe_n
);
  // Named internal events for the checker
  logic want_raw;
  logic want_sync;
  logic vid_own;

  vdma_window u_window (
    .hblank(hblank), .vblank(vblank), .vblank_only(vblank_only),
    .want(want_raw)
  );

  vdma_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(want_raw), .q(want_sync)
  );

  vdma_owner u_owner (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick),
    .req_sync(want_sync), .vid_own(vid_own)
  );

  vdma_ramctl #(.VID_TOP(VID_TOP)) u_ramctl (
    .vid_own(vid_own), .cpu_phase(cpu_phase), .scan_addr(scan_addr),
    .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .bus_addr(bus_addr),
    .bus_rw(bus_rw), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n)
  );

  assign dma_n      = !vid_own;
  assign cpu_rdy    = !vid_own;
  assign cpu_be     = !vid_own;
  assign cpu_buf_oe = !vid_own;
  assign vid_buf_oe = vid_own;
endmodule

// File: rtl/vdma_bus_arbiter_chk.sv
module vdma_bus_arbiter_chk #(
  parameter logic [2:0] VID_TOP = 3'b001
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_tick,
  input logic        cpu_phase,
  input logic        dma_n,
  input logic        cpu_rdy,
  input logic        cpu_be,
  input logic        cpu_buf_oe,
  input logic        vid_buf_oe,
  input logic [15:0] bus_addr,
  input logic        bus_rw,
  input logic        ram_cs_n
);
  // R4
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_n |-> (!cpu_rdy && !cpu_be && !cpu_buf_oe && vid_buf_oe));
  // R4
  cpu_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_n |-> (cpu_rdy && cpu_be && cpu_buf_oe && !vid_buf_oe));
  // R5
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_n |-> (bus_addr[15:13] == VID_TOP));
  // R6
  video_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_n |-> bus_rw);
  // R8
  forced_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_n && !bus_addr[15]) |-> !ram_cs_n);
  // R9
  first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_n && !cpu_phase) |-> ram_cs_n);
  // R3
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_n != $past(dma_n)) |-> $past(cpu_tick));
endmodule

bind vdma_bus_arbiter vdma_bus_arbiter_chk #(.VID_TOP(VID_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .cpu_phase(cpu_phase),
  .dma_n(dma_n), .cpu_rdy(cpu_rdy), .cpu_be(cpu_be),
  .cpu_buf_oe(cpu_buf_oe), .vid_buf_oe(vid_buf_oe), .bus_addr(bus_addr),
  .bus_rw(bus_rw), .ram_cs_n(ram_cs_n)
);

// File: tb/vdma_bus_arbiter_bench.sv
module vdma_bus_arbiter_bench;
  localparam int S = 2;
  localparam logic [2:0] TOP = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hblank = 1'b1, vblank = 1'b1, vblank_only = 1'b0;
  logic cpu_tick = 1'b0, cpu_phase = 1'b0;
  logic [12:0] scan_addr = '0;
  logic [15:0] cpu_addr = '0;
  logic cpu_rw = 1'b1;
  logic dma_n, cpu_rdy, cpu_be, cpu_buf_oe, vid_buf_oe;
  logic [15:0] bus_addr;
  logic bus_rw, ram_cs_n, ram_oe_n;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vdma_bus_arbiter #(.SYNC_STAGES(S), .VID_TOP(TOP)) u_vdma_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .hblank(hblank), .vblank(vblank),
    .vblank_only(vblank_only), .cpu_tick(cpu_tick), .cpu_phase(cpu_phase),
    .scan_addr(scan_addr), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .dma_n(dma_n), .cpu_rdy(cpu_rdy), .cpu_be(cpu_be),
    .cpu_buf_oe(cpu_buf_oe), .vid_buf_oe(vid_buf_oe), .bus_addr(bus_addr),
    .bus_rw(bus_rw), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n)
  );

  // Reference model: queue of past requests, owner bit
  bit req_q[$];
  bit own_m = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q.delete();
      for (int i = 0; i < S; i++) req_q.push_back(1'b0);
      own_m = 0;
    end else begin
      bit oldest, req_now;
      oldest = req_q.pop_front();
      // R1 / R2 request rule
      if (vblank_only) req_now = (vblank == 1'b0);
      else             req_now = (hblank == 1'b0) && (vblank == 1'b0);
      req_q.push_back(req_now);
      if (cpu_tick) own_m = oldest; // R3
    end
  end

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [15:0] ea;
    logic ecs;
    ea = own_m ? {TOP, scan_addr} : cpu_addr;
    if (own_m) ecs = ea[15];
    else       ecs = !(ea[15] == 1'b0 && cpu_phase == 1'b1);
    chk(dma_n === !own_m, "R3 dma_n", dma_n, !own_m);
    chk({cpu_rdy, cpu_be, cpu_buf_oe, vid_buf_oe} === {!own_m, !own_m, !own_m, own_m},
        "R4 stall", {cpu_rdy, cpu_be, cpu_buf_oe, vid_buf_oe},
        {!own_m, !own_m, !own_m, own_m});
    chk(bus_addr === ea, "R5 bus_addr", bus_addr, ea);
    chk(bus_rw === (own_m ? 1'b1 : cpu_rw), "R6 bus_rw", bus_rw, own_m ? 1'b1 : cpu_rw);
    chk(ram_oe_n === ea[14], "R7 ram_oe_n", ram_oe_n, ea[14]);
    chk(ram_cs_n === ecs, own_m ? "R8 ram_cs_n" : "R9 ram_cs_n", ram_cs_n, ecs);
  endtask

  int cnt = 0;
  int cpu_div = 2;

  // One cycle: check at negedge, then drive new values.
  task automatic step(input logic hb, input logic vb);
    @(negedge clk);
    compare_all();
    cnt++;
    cpu_phase = ((cnt / cpu_div) % 2) == 1;
    cpu_tick  = (cnt % (2 * cpu_div)) == cpu_div;
    hblank = hb;
    vblank = vb;
    scan_addr = 13'($urandom);
    cpu_addr  = 16'($urandom);
    cpu_rw    = 1'($urandom);
  endtask

  task automatic raster(input int hw, input int ha, input int vh, input int va);
    for (int y = 0; y < vh; y++)
      for (int x = 0; x < hw; x++)
        step(x >= ha, y >= va);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(dma_n === 1'b1, "R10 reset dma_n", dma_n, 1);
    chk(cpu_rdy === 1'b1 && cpu_be === 1'b1, "R10 reset cpu owns", {cpu_rdy, cpu_be}, 2'b11);
    rst_n = 1'b1;
    // R10: held high while blanked
    for (int i = 0; i < 20; i++) begin
      step(1, 1);
      chk(dma_n === 1'b1, "R10 idle", dma_n, 1);
    end
    // R1 normal mode raster
    vblank_only = 0;
    for (int f = 0; f < 3; f++) raster(24, 16, 10, 7);
    // R2 vblank_only raster
    vblank_only = 1;
    for (int f = 0; f < 3; f++) raster(24, 16, 10, 7);
    // R3 short glitches between CPU edges, varied CPU ratios
    for (int d = 1; d <= 4; d++) begin
      cpu_div = d;
      vblank_only = 1'($urandom);
      for (int i = 0; i < 400; i++)
        step(($urandom % 3) != 0, ($urandom % 4) == 0);
    end
    // R9 CPU addresses in both halves, held blanked
    cpu_div = 2;
    vblank_only = 0;
    for (int i = 0; i < 40; i++) step(1, 1);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule